// File: doc/BRIEF.md
# Platform Trust State Controller

This controller follows the security state of a reconfigurable platform and drives the measurement-register commands of an attached trust module. It takes one-cycle event strobes from the platform: power applied, initial image loaded, user-area reconfiguration, certified or uncertified static-area reconfiguration, enabling of a configuration port that nothing monitors, software load, and power removal. In response it issues single-cycle command strobes. These strobes can set or append the static hardware register, overwrite the reconfigurable-area register, reset or extend the software registers, or disable the trust module. It also shows whether the platform is currently able to report its configuration.

The static fabric measurement is chained, so its history stays traceable. The reconfigurable-area measurement is overwritten, because a new user image leaves no trace of the old one. That overwrite is followed by a reset of the software registers, since a new platform is in effect booting. Any action that escapes monitoring drops the platform into a latched non-reporting state. Only a power-off followed by a fresh boot can leave that state.

Hashing, the bus link to the trust module and attestation signing sit outside this block. Commands are registered: an event sampled at a clock edge produces its strobe in the cycle that follows that edge. The state output changes at that same edge.

Top module: `platform_trust_ctrl`

## Requirements
- R1: While reset is held and after it is released, the state output reads 0 (fabric empty), reporting is low and every command strobe is low.
- R2: A power-on event in the fabric-empty state moves to init (state code 1). It then gives static-set, reconf-write and software-reset strobes on three consecutive cycles, starting in the cycle after the event.
- R3: An initial-load-complete event in init, with no command pending, moves to operational (state code 2) and gives no strobe.
- R4: A user-area reconfiguration in operational gives reconf-write in the next cycle and software-reset in the cycle after, and the state stays operational.
- R5: A certified static reconfiguration in operational gives a single static-append strobe.
- R6: A software-load event in operational gives a single software-extend strobe.
- R7: An uncertified static reconfiguration or an unmonitored-port enable, while in init or operational (including during a pending command sequence), gives a trust-disable strobe and moves to trust-module-off (state code 3). This outranks every other event in the same cycle, power-off included.
- R8: In trust-module-off every event except power-off is ignored, power-on included. Power-off returns to fabric empty, and a later power-on restarts the R2 sequence.
- R9: Power-off in init, operational or trust-module-off moves to fabric empty with no strobe and cancels any pending command. In fabric empty a power-off together with a power-on leaves the state unchanged.
- R10: Events that do not apply to the current state, and non-disabling events that arrive while a command sequence is pending, change nothing. They neither alter the state nor raise a strobe.
- R11: At most one command strobe is high in any cycle.
- R12: Reporting is high exactly when the state code is 1 or 2.
- R13: When several non-disabling events coincide in operational, user reconfiguration wins over certified static reconfiguration, which wins over software load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_power_on | input | 1 | Power applied, boot image loading |
| ev_init_done | input | 1 | Initial image fully loaded |
| ev_user_reconf | input | 1 | User area reconfigured |
| ev_static_cert | input | 1 | Static area reconfigured with certified image |
| ev_static_uncert | input | 1 | Static area reconfigured with uncertified image |
| ev_unmon_port | input | 1 | Unmonitored configuration port enabled |
| ev_sw_load | input | 1 | Software loaded on the soft processor |
| ev_power_off | input | 1 | Power removed |
| cmd_static_set | output | 1 | Set static hardware register |
| cmd_static_append | output | 1 | Append to static hardware register |
| cmd_reconf_write | output | 1 | Overwrite reconfigurable-area register |
| cmd_sw_reset | output | 1 | Reset software registers |
| cmd_sw_extend | output | 1 | Extend software registers |
| cmd_tm_disable | output | 1 | Disable the trust module |
| reporting | output | 1 | Platform is in a reporting state |
| state_code | output | 2 | 0 empty, 1 init, 2 operational, 3 trust-module-off |

## Verification
The collision that matters most is a trust-breaking event arriving in the same cycle as a power-off, or in the middle of the three-cycle power-on sequence or the two-cycle user-reconfiguration sequence. The bench provokes these cases by walking each of the four stable states through all 256 combinations of the eight event strobes. It also injects breaking events and power-off directly into pending sequences. A bench model written separately from the RTL decides the winning command and next state for each case. The bench then compares the full strobe vector, the state code and the reporting flag one cycle after the event.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_INIT  = 2'd1,
    ST_OPER  = 2'd2,
    ST_TMOFF = 2'd3
  } plat_state_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RECONF = 2'd1,
    PH_SWRST  = 2'd2
  } meas_phase_e;

  localparam int NUM_CMD = 6;
  localparam int CMD_W   = $clog2(NUM_CMD + 1);

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE          = 3'd0,
    CMD_STATIC_SET    = 3'd1,
    CMD_STATIC_APPEND = 3'd2,
    CMD_RECONF_WRITE  = 3'd3,
    CMD_SW_RESET      = 3'd4,
    CMD_SW_EXTEND     = 3'd5,
    CMD_TM_DISABLE    = 3'd6
  } trust_cmd_e;

  typedef struct packed {
    logic power_on;
    logic init_done;
    logic user_reconf;
    logic static_cert;
    logic static_uncert;
    logic unmon_port;
    logic sw_load;
    logic power_off;
  } plat_events_t;

  function automatic logic is_reporting(plat_state_e s);
    return (s == ST_INIT) || (s == ST_OPER);
  endfunction

  // strobe bit i carries command code i+1
  function automatic logic [NUM_CMD-1:0] cmd_to_strobes(trust_cmd_e c);
    logic [NUM_CMD-1:0] v;
    for (int i = 0; i < NUM_CMD; i++) v[i] = (int'(c) == i + 1);
    return v;
  endfunction

endpackage

// File: rtl/ptc_decide.sv
module ptc_decide
  import ptc_pkg::*;
(
  input  plat_state_e  state,
  input  meas_phase_e  phase,
  input  plat_events_t ev,
  output plat_state_e  nxt_state,
  output meas_phase_e  nxt_phase,
  output trust_cmd_e   cmd,
  output logic         trust_break,
  output logic         teardown
);

  assign trust_break = (ev.static_uncert | ev.unmon_port) & is_reporting(state);
  assign teardown    = ev.power_off & (state != ST_EMPTY);

  always_comb begin
    nxt_state = state;
    nxt_phase = phase;
    cmd       = CMD_NONE;
    if (trust_break) begin
      nxt_state = ST_TMOFF;
      nxt_phase = PH_IDLE;
      cmd       = CMD_TM_DISABLE;
    end else if (teardown) begin
      nxt_state = ST_EMPTY;
      nxt_phase = PH_IDLE;
    end else if (phase == PH_RECONF) begin
      cmd       = CMD_RECONF_WRITE;
      nxt_phase = PH_SWRST;
    end else if (phase == PH_SWRST) begin
      cmd       = CMD_SW_RESET;
      nxt_phase = PH_IDLE;
    end else begin
      case (state)
        ST_EMPTY: begin
          if (ev.power_on && !ev.power_off) begin
            nxt_state = ST_INIT;
            nxt_phase = PH_RECONF;
            cmd       = CMD_STATIC_SET;
          end
        end
        ST_INIT: begin
          if (ev.init_done) nxt_state = ST_OPER;
        end
        ST_OPER: begin
          if (ev.user_reconf) begin
            cmd       = CMD_RECONF_WRITE;
            nxt_phase = PH_SWRST;
          end else if (ev.static_cert) begin
            cmd = CMD_STATIC_APPEND;
          end else if (ev.sw_load) begin
            cmd = CMD_SW_EXTEND;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ptc_cmd_out.sv
module ptc_cmd_out
  import ptc_pkg::*;
#(
  parameter int N = ptc_pkg::NUM_CMD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  trust_cmd_e   cmd,
  output logic [N-1:0] strobe_q
);

  logic [N-1:0] strobe_d;
  assign strobe_d = cmd_to_strobes(cmd);

  for (genvar g = 0; g < N; g++) begin : g_flop
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q[g] <= 1'b0;
      else        strobe_q[g] <= strobe_d[g];
    end
  end

  // R11
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_q));

endmodule

// File: rtl/platform_trust_ctrl.sv
module platform_trust_ctrl
  import ptc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_power_on,
  input  logic       ev_init_done,
  input  logic       ev_user_reconf,
  input  logic       ev_static_cert,
  input  logic       ev_static_uncert,
  input  logic       ev_unmon_port,
  input  logic       ev_sw_load,
  input  logic       ev_power_off,
  output logic       cmd_static_set,
  output logic       cmd_static_append,
  output logic       cmd_reconf_write,
  output logic       cmd_sw_reset,
  output logic       cmd_sw_extend,
  output logic       cmd_tm_disable,
  output logic       reporting,
  output logic [1:0] state_code
);

  plat_events_t       ev;
  plat_state_e        state_q, state_d;
  meas_phase_e        phase_q, phase_d;
  trust_cmd_e         cmd_d;
  logic               trust_break, teardown;
  logic [NUM_CMD-1:0] strobes;

  assign ev = '{power_on: ev_power_on, init_done: ev_init_done,
                user_reconf: ev_user_reconf, static_cert: ev_static_cert,
                static_uncert: ev_static_uncert, unmon_port: ev_unmon_port,
                sw_load: ev_sw_load, power_off: ev_power_off};

  ptc_decide u_decide (
    .state      (state_q),
    .phase      (phase_q),
    .ev         (ev),
    .nxt_state  (state_d),
    .nxt_phase  (phase_d),
    .cmd        (cmd_d),
    .trust_break(trust_break),
    .teardown   (teardown)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_EMPTY;
      phase_q <= PH_IDLE;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  ptc_cmd_out #(.N(NUM_CMD)) u_cmd_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd_d),
    .strobe_q(strobes)
  );

  assign cmd_static_set    = strobes[0];
  assign cmd_static_append = strobes[1];
  assign cmd_reconf_write  = strobes[2];
  assign cmd_sw_reset      = strobes[3];
  assign cmd_sw_extend     = strobes[4];
  assign cmd_tm_disable    = strobes[5];
  assign reporting         = is_reporting(state_q);
  assign state_code        = state_q;

  // R7
  break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trust_break |=> (state_q == ST_TMOFF) && cmd_tm_disable);

  // R8
  tmoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TMOFF && !ev_power_off) |=> (state_q == ST_TMOFF) && (strobes == '0));

  // R2
  seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_static_set && !ev_power_off && !ev_static_uncert && !ev_unmon_port) |=> cmd_reconf_write);

  // R4
  swrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reconf_write && !ev_power_off && !ev_static_uncert && !ev_unmon_port) |=> cmd_sw_reset);

  // R9
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (teardown && !trust_break) |=> (state_q == ST_EMPTY) && (strobes == '0));

  // R12
  report_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reporting) |-> $past(ev_power_on));

endmodule

// File: tb/platform_trust_ctrl_bench.sv
module platform_trust_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ev = 8'h00;  // 0 pon,1 init,2 user,3 cert,4 uncert,5 unmon,6 sw,7 poff
  logic       s_set, s_app, s_rw, s_swr, s_swe, s_dis, rep;
  logic [1:0] st;
  int         checks = 0;
  int         fails = 0;

  localparam logic [7:0] E_PON = 8'h01, E_INIT = 8'h02, E_USER = 8'h04, E_CERT = 8'h08,
                         E_UNC = 8'h10, E_UNM = 8'h20, E_SW = 8'h40, E_POFF = 8'h80;

  always #10 clk = ~clk;

  platform_trust_ctrl u_platform_trust_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ev_power_on(ev[0]), .ev_init_done(ev[1]), .ev_user_reconf(ev[2]),
    .ev_static_cert(ev[3]), .ev_static_uncert(ev[4]), .ev_unmon_port(ev[5]),
    .ev_sw_load(ev[6]), .ev_power_off(ev[7]),
    .cmd_static_set(s_set), .cmd_static_append(s_app), .cmd_reconf_write(s_rw),
    .cmd_sw_reset(s_swr), .cmd_sw_extend(s_swe), .cmd_tm_disable(s_dis),
    .reporting(rep), .state_code(st)
  );

  function automatic logic [5:0] got_cmds();
    return {s_dis, s_swe, s_swr, s_rw, s_app, s_set};
  endfunction

  // drive at a falling edge, return at the next falling edge (one rising edge between)
  task automatic tick(input logic [7:0] e);
    ev = e;
    @(negedge clk);
    ev = 8'h00;
  endtask

  task automatic chk(input string req, input logic [5:0] exp_cmd, input int exp_st);
    logic exp_rep;
    exp_rep = (exp_st == 1) || (exp_st == 2);
    checks++;
    if (got_cmds() !== exp_cmd || int'(st) != exp_st || rep !== exp_rep) begin
      fails++;
      $display("FAIL %s: cmds=%b state=%0d rep=%b, expected cmds=%b state=%0d rep=%b",
               req, got_cmds(), st, rep, exp_cmd, exp_st, exp_rep);
    end
  endtask

  task automatic goto(input int s);
    tick(E_POFF);
    tick(8'h00);
    if (s >= 1) begin
      tick(E_PON); tick(8'h00); tick(8'h00);
    end
    if (s == 2) tick(E_INIT);
    if (s == 3) tick(E_UNC);
  endtask

  // bench model: result of one event vector from a settled state
  task automatic model(input int s, input logic [7:0] e, output int ns,
                       output logic [5:0] c, output string req);
    bit brk;
    brk = (e[4] || e[5]) && (s == 1 || s == 2);
    ns = s; c = 6'b0; req = "R10";
    if (brk) begin
      ns = 3; c = 6'b100000; req = "R7";
    end else if (e[7]) begin
      ns = 0; req = "R9";
    end else begin
      case (s)
        0: if (e[0]) begin ns = 1; c = 6'b000001; req = "R2"; end
        1: if (e[1]) begin ns = 2; req = "R3"; end
        2: begin
          if (e[2])      begin c = 6'b000100; req = "R4"; end
          else if (e[3]) begin c = 6'b000010; req = "R5"; end
          else if (e[6]) begin c = 6'b010000; req = "R6"; end
          if (e[2] && (e[3] || e[6])) req = "R13";
          else if (e[3] && e[6]) req = "R13";
        end
        default: req = "R8";
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int ns; logic [5:0] c; string req;
    ev = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 6'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 6'b0, 0);

    // R2 power-on sequence, R12 reporting in init
    tick(E_PON); chk("R2 static set", 6'b000001, 1);
    tick(8'h00); chk("R2 reconf write", 6'b000100, 1);
    tick(8'h00); chk("R2 software reset", 6'b001000, 1);
    tick(8'h00); chk("R12 init idle", 6'b0, 1);

    // R10 events during a pending sequence are ignored
    goto(0);
    tick(E_PON); chk("R2 set", 6'b000001, 1);
    tick(E_INIT | E_SW | E_USER | E_CERT); chk("R10 pending ignore", 6'b000100, 1);
    tick(E_INIT); chk("R10 pending ignore 2", 6'b001000, 1);
    tick(8'h00); chk("R10 still init", 6'b0, 1);

    // R9 power-off cancels pending sequence
    goto(0);
    tick(E_PON); chk("R9 set", 6'b000001, 1);
    tick(E_POFF); chk("R9 abort", 6'b0, 0);
    tick(8'h00); chk("R9 no leftover", 6'b0, 0);

    // R7 break during pending user-reconf sequence, beats power-off
    goto(2);
    tick(E_USER); chk("R4 reconf write", 6'b000100, 2);
    tick(E_UNM | E_POFF); chk("R7 break in sequence", 6'b100000, 3);
    tick(8'h00); chk("R7 no leftover", 6'b0, 3);

    // R8 sticky off; power-on ignored; power-off then reboot
    tick(E_PON); chk("R8 pon ignored", 6'b0, 3);
    tick(E_POFF); chk("R8 power off", 6'b0, 0);
    tick(E_PON); chk("R8 reboot set", 6'b000001, 1);

    // sweep: every settled state against every event combination
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 256; e++) begin
        goto(s);
        model(s, 8'(e), ns, c, req);
        tick(8'(e));
        chk({req, " sweep"}, c, ns);
        if (c == 6'b000100) begin
          tick(8'h00);
          chk("R4 sweep second", 6'b001000, 2);
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule